// File: doc/BRIEF.md
# Semaphore-Counted Descriptor Channel Controller

This block is the command front end of a four-channel crypto co-processor. Software gives each channel the address of a descriptor chain and adds a work count to that channel's semaphore. While a channel is enabled, holds a nonzero count and has a clear status, the controller may pick it. It reads the descriptor from memory one word at a time over a simple read port and hands the decoded control words and addresses to an external processing engine through a start/done handshake. When the engine finishes, the controller writes a result code back into the descriptor's status word.

Each descriptor's first control word decides what happens on completion. One bit lowers the semaphore by one, and another sets the channel's flag in the global interrupt status. The controller then moves on to the next-command address. It keeps going while the count is nonzero and goes idle when the count reaches zero. Channels compete in fixed priority, and the winner is chosen again after every descriptor. If the engine returns a nonzero result, the channel is stopped until software clears its status.

Descriptor layout in memory (eight 32-bit words, byte offsets from the descriptor address): 0x00 next-command address, 0x04 control word 0, 0x08 control word 1, 0x0C source, 0x10 destination, 0x14 byte count, 0x18 payload address, 0x1C status (written by the controller).

Top module: `chseq_top`

## Requirements
- R1: After reset every register reads zero except the capability register, `irq` is low, and no memory read, memory write or engine start is issued.
- R2: A write to a channel's semaphore register (channel base 0x100 + 0x40·n, offset 0x10) adds wdata[7:0] to that channel's count, saturating at 0xFF. A read of the same offset returns the count.
- R3: A channel is served only when its bit in the enable mask (register 0x20, bits 7:0) is set and its count is nonzero. The descriptor is read as seven words at command pointer + 0, 4, … 24, in that order, and the read address is held until `mem_rd_valid` is seen.
- R4: After the seventh word has been read, `eng_start` is high for exactly one cycle. While it is high, `eng_chan` holds the channel and `eng_ctrl0`, `eng_ctrl1`, `eng_src`, `eng_dst`, `eng_size` and `eng_payload` hold descriptor words 1 to 6 unchanged. These include the cipher, hash, encrypt, init, key and terminate flags in control word 0, and the hash and chaining selects in control word 1.
- R5: On a zero engine result, the controller writes zero to descriptor address + 0x1C. Control word 0 bit 1 lowers the semaphore by one. The command pointer register then takes the next-command address, and the chain continues while the count is nonzero and stops at zero.
- R6: On a zero engine result with control word 0 bit 0 set, the channel's bit in global status (0x10, bit n) is set. Writing ones to 0x18 clears the matching bits.
- R7: When several channels are ready, the lowest-numbered one is served. The choice is made again after every descriptor.
- R8: A nonzero engine result is written to descriptor address + 0x1C and into the channel status register (offset 0x20), and it sets global status bit n whatever control word 0 says. The semaphore and command pointer stay unchanged, and the channel is not served again until ones are written to its status-clear register (offset 0x28).
- R9: `irq` is the OR of global status bits n, each gated by bit n of the control register at 0x00.
- R10: The register at 0x40 always reads 0x0005_0001, and writes to it have no effect.
- R11: The enable mask register at 0x20 reads back its bits 7:0 as written. A cleared bit keeps a channel with a nonzero count idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_rd_en | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Read data valid; completes the request |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Status write-back strobe (one cycle) |
| mem_wr_addr | output | 32 | Status word address |
| mem_wr_data | output | 32 | Status value |
| eng_start | output | 1 | One-cycle operation request to the engine |
| eng_chan | output | 2 | Channel of the operation |
| eng_ctrl0 | output | 32 | Control word 0 |
| eng_ctrl1 | output | 32 | Control word 1 |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_size | output | 32 | Byte count |
| eng_payload | output | 32 | Payload address |
| eng_done | input | 1 | Engine finished |
| eng_status | input | 8 | Engine result; nonzero means error |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the edge that samples `reg_we`, and reads are combinational, so the bench checks read data 1 ns after it sets the address. Each descriptor word completes at the edge where `mem_rd_valid` meets `mem_rd_en`. `eng_start` follows one edge after the seventh word, and the status write-back is issued in the cycle after the edge that samples `eng_done`. The interrupt status, and with it `irq`, changes at the edge that closes that write-back cycle. The bench's behavioural model applies each event at the falling edge before the edge that acts on it, and it compares `irq` 1 ns after every rising edge and the handshake outputs at every falling edge.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_WB} state_e;

    // global register offsets
    localparam int CTRL_OFF  = 'h00;
    localparam int GSTAT_OFF = 'h10;
    localparam int GCLR_OFF  = 'h18;
    localparam int CHEN_OFF  = 'h20;
    localparam int CAPS_OFF  = 'h40;
    // per-channel window
    localparam int CH_BASE      = 'h100;
    localparam int CH_STRIDE_LG = 6;
    localparam int CH_PTR_OFF   = 'h00;
    localparam int CH_SEMA_OFF  = 'h10;
    localparam int CH_STAT_OFF  = 'h20;
    localparam int CH_SCLR_OFF  = 'h28;

    // descriptor words 0..6 are fetched, word 7 is written back
    localparam int FETCH_WORDS = 7;
    localparam int STAT_BYTE   = 'h1C;
    localparam int C0_IRQ      = 0;
    localparam int C0_SEMA_DEC = 1;

    localparam logic [31:0] CAPS_VAL = 32'h0005_0001;

    typedef struct packed {
        logic       ctrl;
        logic       gstat;
        logic       gclr;
        logic       chen;
        logic       caps;
        logic       ptr;
        logic       sema;
        logic       cst;
        logic       sclr;
        logic [2:0] ch;
    } regsel_t;
endpackage

// File: rtl/chseq_regdec.sv
module chseq_regdec
    import chseq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int RA_W = 12
) (
    input  logic [RA_W-1:0] addr,
    output regsel_t         sel
);
    logic [RA_W-1:0] rel;

    always_comb begin
        sel = '0;
        rel = addr - RA_W'(CH_BASE);
        if (addr == RA_W'(CTRL_OFF))  sel.ctrl  = 1'b1;
        if (addr == RA_W'(GSTAT_OFF)) sel.gstat = 1'b1;
        if (addr == RA_W'(GCLR_OFF))  sel.gclr  = 1'b1;
        if (addr == RA_W'(CHEN_OFF))  sel.chen  = 1'b1;
        if (addr == RA_W'(CAPS_OFF))  sel.caps  = 1'b1;
        if ((addr >= RA_W'(CH_BASE)) && (int'(rel >> CH_STRIDE_LG) < NCH)) begin
            sel.ch = 3'(rel >> CH_STRIDE_LG);
            case (int'(rel[CH_STRIDE_LG-1:0]))
                CH_PTR_OFF:  sel.ptr  = 1'b1;
                CH_SEMA_OFF: sel.sema = 1'b1;
                CH_STAT_OFF: sel.cst  = 1'b1;
                CH_SCLR_OFF: sel.sclr = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/chseq_arb.sv
module chseq_arb #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gnt_valid,
    output logic [CW-1:0] gnt_idx
);
    // scan from the top so the lowest requesting index is the one kept
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CW'(i);
            end
        end
    end

    p_gnt_is_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);
    p_no_lower_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((req & ((N'(1) << gnt_idx) - N'(1))) == '0));
endmodule

// File: rtl/chseq_top.sv
module chseq_top
    import chseq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int SEMA_W = 8,
    parameter int STAT_W = 8,
    parameter int RA_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd_en,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [31:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              eng_start,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] eng_chan,
    output logic [31:0]       eng_ctrl0,
    output logic [31:0]       eng_ctrl1,
    output logic [31:0]       eng_src,
    output logic [31:0]       eng_dst,
    output logic [31:0]       eng_size,
    output logic [31:0]       eng_payload,
    input  logic              eng_done,
    input  logic [STAT_W-1:0] eng_status,
    output logic              irq
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [2:0] LAST_W = 3'(FETCH_WORDS - 1);

    typedef struct packed {
        state_e                           st;
        logic [CH_W-1:0]                  cur;
        logic [2:0]                       widx;
        logic [FETCH_WORDS-1:0][31:0]     dw;
        logic [STAT_W-1:0]                res;
        logic [NCH-1:0][31:0]             ptr;
        logic [NCH-1:0][SEMA_W-1:0]       sema;
        logic [NCH-1:0][STAT_W-1:0]       cst;
        logic [NCH-1:0]                   gst;
        logic [NCH-1:0]                   ie;
        logic [7:0]                       chen;
    } st_t;

    st_t             st_d, st_q;
    regsel_t         rsel;
    logic [CH_W-1:0] rch;
    logic [NCH-1:0]  ready;
    logic            gnt_v;
    logic [CH_W-1:0] gnt_i;
    logic [SEMA_W:0] sum;

    chseq_regdec #(.NCH(NCH), .RA_W(RA_W)) u_dec (.addr(reg_addr), .sel(rsel));

    assign rch = CH_W'(rsel.ch);

    always_comb begin
        for (int c = 0; c < NCH; c++)
            ready[c] = st_q.chen[c] && (st_q.sema[c] != '0) && (st_q.cst[c] == '0);
    end

    chseq_arb #(.N(NCH), .CW(CH_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(ready), .gnt_valid(gnt_v), .gnt_idx(gnt_i)
    );

    always_comb begin
        st_d        = st_q;
        mem_rd_en   = 1'b0;
        mem_rd_addr = st_q.ptr[st_q.cur] + 32'({st_q.widx, 2'b00});
        mem_wr_en   = 1'b0;
        mem_wr_addr = st_q.ptr[st_q.cur] + 32'(STAT_BYTE);
        mem_wr_data = 32'(st_q.res);
        eng_start   = 1'b0;
        sum         = {1'b0, st_q.sema[rch]} + {1'b0, reg_wdata[SEMA_W-1:0]};

        // software side
        if (reg_we) begin
            if (rsel.ctrl) st_d.ie   = reg_wdata[NCH-1:0];
            if (rsel.gclr) st_d.gst  = st_q.gst & ~reg_wdata[NCH-1:0];
            if (rsel.chen) st_d.chen = reg_wdata[7:0];
            if (rsel.ptr)  st_d.ptr[rch] = reg_wdata;
            if (rsel.sema) st_d.sema[rch] = sum[SEMA_W] ? '1 : sum[SEMA_W-1:0];
            if (rsel.sclr) st_d.cst[rch] = st_q.cst[rch] & ~reg_wdata[STAT_W-1:0];
        end

        // descriptor sequencer (its updates win over software in the same cycle)
        unique case (st_q.st)
            ST_IDLE: begin
                if (gnt_v) begin
                    st_d.cur  = gnt_i;
                    st_d.widx = '0;
                    st_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                if (mem_rd_valid) begin
                    st_d.dw[st_q.widx] = mem_rd_data;
                    if (st_q.widx == LAST_W) st_d.st   = ST_ISSUE;
                    else                     st_d.widx = st_q.widx + 3'd1;
                end
            end
            ST_ISSUE: begin
                eng_start = 1'b1;
                st_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (eng_done) begin
                    st_d.res = eng_status;
                    st_d.st  = ST_WB;
                end
            end
            ST_WB: begin
                mem_wr_en = 1'b1;
                if (st_q.res != '0) begin
                    st_d.cst[st_q.cur] = st_q.res;
                    st_d.gst[st_q.cur] = 1'b1;
                end else begin
                    st_d.ptr[st_q.cur] = st_q.dw[0];
                    if (st_q.dw[1][C0_SEMA_DEC])
                        st_d.sema[st_q.cur] = st_d.sema[st_q.cur] - SEMA_W'(1);
                    if (st_q.dw[1][C0_IRQ])
                        st_d.gst[st_q.cur] = 1'b1;
                end
                st_d.st = ST_IDLE;
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{st: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (rsel.ctrl)  reg_rdata = 32'(st_q.ie);
        if (rsel.gstat) reg_rdata = 32'(st_q.gst);
        if (rsel.chen)  reg_rdata = 32'(st_q.chen);
        if (rsel.caps)  reg_rdata = CAPS_VAL;
        if (rsel.ptr)   reg_rdata = st_q.ptr[rch];
        if (rsel.sema)  reg_rdata = 32'(st_q.sema[rch]);
        if (rsel.cst)   reg_rdata = 32'(st_q.cst[rch]);
    end

    assign eng_chan    = st_q.cur;
    assign eng_ctrl0   = st_q.dw[1];
    assign eng_ctrl1   = st_q.dw[2];
    assign eng_src     = st_q.dw[3];
    assign eng_dst     = st_q.dw[4];
    assign eng_size    = st_q.dw[5];
    assign eng_payload = st_q.dw[6];
    assign irq         = |(st_q.gst & st_q.ie);

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en, eng_start}));
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
    p_sema_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (st_q.sema[st_q.cur] != '0));
    p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && (mem_wr_data != '0)) |=> (st_q.cst != '0));
endmodule

// File: tb/chseq_top_tb_top.sv
module chseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en, mem_wr_en, eng_start, irq;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [1:0]  eng_chan;
    logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size, eng_payload;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_status = '0;

    always #2.5 clk = ~clk;

    chseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .eng_start(eng_start), .eng_chan(eng_chan),
        .eng_ctrl0(eng_ctrl0), .eng_ctrl1(eng_ctrl1), .eng_src(eng_src), .eng_dst(eng_dst),
        .eng_size(eng_size), .eng_payload(eng_payload), .eng_done(eng_done),
        .eng_status(eng_status), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] da, c0, c1, src, dst, sz, pay;
        logic [7:0]  err;
    } op_t;

    op_t         exp_q[$];
    op_t         cur_op;
    logic [31:0] mem [256];
    logic [3:0]  m_gst = '0;
    logic [3:0]  m_ie  = '0;
    int          nchk = 0, nfail = 0, eng_cnt = 0;
    bit          busy = 1'b0, live = 1'b0;

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] c0,
                            input logic [31:0] c1);
        mem[a[9:2]]     = nxt;
        mem[a[9:2] + 1] = c0;
        mem[a[9:2] + 2] = c1;
        mem[a[9:2] + 3] = 32'h5000_0000 | a;
        mem[a[9:2] + 4] = 32'h6000_0000 | a;
        mem[a[9:2] + 5] = 32'h0000_0010 + a;
        mem[a[9:2] + 6] = 32'h7000_0000 | a;
        mem[a[9:2] + 7] = 32'hDEAD_BEEF;
    endtask

    task automatic push_op(input logic [1:0] ch, input logic [31:0] a, input logic [7:0] err);
        op_t o;
        o.ch = ch; o.da = a; o.err = err;
        o.c0 = mem[a[9:2] + 1]; o.c1 = mem[a[9:2] + 2]; o.src = mem[a[9:2] + 3];
        o.dst = mem[a[9:2] + 4]; o.sz = mem[a[9:2] + 5]; o.pay = mem[a[9:2] + 6];
        exp_q.push_back(o);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 12'h000) m_ie = d[3:0];
        if (a == 12'h018) m_gst = m_gst & ~d[3:0];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, 256'(reg_rdata), 256'(exp));
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((exp_q.size() != 0 || busy) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 4000) check("R3 chain did not finish", 256'(exp_q.size()), 256'(0));
        repeat (12) @(negedge clk);
    endtask

    // memory, engine stub and handshake monitor
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done   = 1'b1;
                eng_status = cur_op.err;
            end
        end
        if (mem_rd_en && !mem_rd_valid) begin
            if (exp_q.size() == 0)
                check("R3/R11 fetch with no work due", 256'(mem_rd_addr), 256'(0));
            else
                check("R3 fetch address", 256'(mem_rd_addr[31:5]), 256'(exp_q[0].da[31:5]));
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem[mem_rd_addr[9:2]];
        end else begin
            mem_rd_valid = 1'b0;
        end
        if (eng_start) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected engine start", 256'(eng_start), 256'(0));
            end else begin
                cur_op = exp_q.pop_front();
                check("R4/R7 engine request",
                      {eng_chan, eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size, eng_payload},
                      {cur_op.ch, cur_op.c0, cur_op.c1, cur_op.src, cur_op.dst, cur_op.sz, cur_op.pay});
                busy    = 1'b1;
                eng_cnt = 3;
            end
        end
        if (mem_wr_en) begin
            check("R5/R8 status write-back", {mem_wr_addr, mem_wr_data},
                  {cur_op.da + 32'h1C, 32'(cur_op.err)});
            mem[mem_wr_addr[9:2]] = mem_wr_data;
            if (cur_op.err != 0 || cur_op.c0[0]) m_gst[cur_op.ch] = 1'b1;
            busy = 1'b0;
        end
    end

    // interrupt compared on every clock
    always @(posedge clk) begin
        #1;
        if (live) check("R9/R6 irq", 256'(irq), 256'(|(m_gst & m_ie)));
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        foreach (mem[i]) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R1 reset state
        rd("R1 ctrl", 12'h000, 32'h0);
        rd("R1 gstat", 12'h010, 32'h0);
        rd("R1 chen", 12'h020, 32'h0);
        rd("R1 ch1 ptr", 12'h140, 32'h0);
        rd("R1 ch1 sema", 12'h150, 32'h0);
        check("R1 no activity", {mem_rd_en, mem_wr_en, eng_start, irq}, 4'b0);
        // R10 capability
        rd("R10 caps", 12'h040, 32'h0005_0001);
        wr(12'h040, 32'hFFFF_FFFF);
        rd("R10 caps after write", 12'h040, 32'h0005_0001);

        // R2 / R11: count while disabled does nothing
        put_desc(32'h000, 32'h040, 32'h0000_3043, 32'h0002_0000);
        put_desc(32'h040, 32'h080, 32'h0000_0B22, 32'h0000_0010);
        put_desc(32'h080, 32'h0C0, 32'h0000_0123, 32'h0000_0000);
        wr(12'h140, 32'h000);
        wr(12'h150, 32'h1);
        repeat (20) @(negedge clk);
        rd("R11 disabled channel keeps count", 12'h150, 32'h1);
        wr(12'h150, 32'h2);
        rd("R2 semaphore add", 12'h150, 32'h3);

        // R3 R4 R5 R6 chain of three on channel 1
        wr(12'h000, 32'h2);
        push_op(2'd1, 32'h000, 8'h00);
        push_op(2'd1, 32'h040, 8'h00);
        push_op(2'd1, 32'h080, 8'h00);
        wr(12'h020, 32'h02);
        wait_idle();
        rd("R5 count reaches zero", 12'h150, 32'h0);
        rd("R5 pointer follows chain", 12'h140, 32'h0C0);
        rd("R6 gstat bit1", 12'h010, 32'h2);
        rd("R11 enable readback", 12'h020, 32'h02);
        wr(12'h018, 32'h2);
        rd("R6 write-one clear", 12'h010, 32'h0);

        // R7 priority: ch0 chain of two and ch2 single, enabled together
        wr(12'h020, 32'h00);
        put_desc(32'h100, 32'h140, 32'h0000_0043, 32'h0000_0000);
        put_desc(32'h140, 32'h180, 32'h0000_0022, 32'h0002_0010);
        put_desc(32'h180, 32'h1C0, 32'h0000_0063, 32'h0002_0000);
        wr(12'h100, 32'h100);
        wr(12'h110, 32'h2);
        wr(12'h180, 32'h180);
        wr(12'h190, 32'h1);
        push_op(2'd0, 32'h100, 8'h00);
        push_op(2'd0, 32'h140, 8'h00);
        push_op(2'd2, 32'h180, 8'h00);
        wr(12'h000, 32'h5);
        wr(12'h020, 32'h05);
        wait_idle();
        rd("R7 gstat ch0 and ch2", 12'h010, 32'h5);
        wr(12'h018, 32'hF);

        // R8 error halts channel 3
        wr(12'h000, 32'h0);
        put_desc(32'h1C0, 32'h200, 32'h0000_0042, 32'h0000_0000);
        wr(12'h1C0, 32'h1C0);
        push_op(2'd3, 32'h1C0, 8'h5A);
        wr(12'h1D0, 32'h1);
        wr(12'h020, 32'h08);
        wait_idle();
        rd("R8 channel status", 12'h1E0, 32'h5A);
        rd("R8 count kept", 12'h1D0, 32'h1);
        rd("R8 pointer kept", 12'h1C0, 32'h1C0);
        rd("R8 gstat set without bit0", 12'h010, 32'h8);
        repeat (30) @(negedge clk);
        wr(12'h000, 32'h8);
        repeat (3) @(negedge clk);
        check("R9 gated irq high", 256'(irq), 256'(1));
        push_op(2'd3, 32'h1C0, 8'h00);
        wr(12'h1E8, 32'hFF);
        wait_idle();
        rd("R8 status cleared", 12'h1E0, 32'h0);
        rd("R8 retry consumed count", 12'h1D0, 32'h0);
        rd("R8 retry advanced pointer", 12'h1C0, 32'h200);
        wr(12'h018, 32'h8);
        check("R9 irq low after clear", 256'(irq), 256'(0));

        // R2 saturation on a disabled channel
        wr(12'h020, 32'h00);
        wr(12'h190, 32'hF0);
        wr(12'h190, 32'h20);
        rd("R2 semaphore saturates", 12'h190, 32'hFF);

        live = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule